// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives serial NOR flash devices over a single chip-select SPI bus in mode 3. Software loads an address register and a data register, then writes a command word. Each command word starts one bus operation. That operation may contain an opcode byte, up to three address bytes, up to fifteen dummy bytes and up to four data bytes. The data bytes are either sent or captured, as the direction bit selects. A pending flag stays high while the operation runs. An error flag records commands that could not be accepted.

A keep-selected bit holds chip select low after a command ends. Several command writes can then form one flash transaction. The opcode is sent only when a command opens a new transaction, which means chip select was high when the command was accepted. Commands that continue a held transaction send only their address, dummy and data phases. A continuation command with all lengths zero and keep-selected clear only releases chip select.

Register writes go through one write port with a 2-bit select: 0 selects the address, 1 the data, 2 the command and 3 the control word. The data register is always visible on `data_q`.

Top module: `sflash_cmd_seq`

## Requirements
- R1: After reset, cs_n=1, sck=1, mosi=0, pend=0, err=0 and data_q=0.
- R2: Command word bits [7:0] hold the opcode. It is sent first, MSB first, only when chip select was deasserted at the moment the command was accepted. A command accepted while chip select is held sends no opcode.
- R3: Command bits [9:8] give the address length, 0 to 3 bytes. The bytes come from address register bits [23:0], most significant used byte first. For example, length 2 sends bits [15:8] and then bits [7:0].
- R4: Command bits [13:10] give the dummy length, 0 to 15 bytes. Each dummy byte is driven as eight zero bits on mosi.
- R5: Command bits [16:14] give the data length, 0 to 4 bytes. When bit [17] is 1 (write), data register byte 0 (bits [7:0]) is sent first, then byte 1 and so on, each MSB first. A write command leaves the data register unchanged.
- R6: When bit [17] is 0 (read), the bits sampled from miso fill data byte 0 first, each byte MSB first. Bytes at or above the data length keep their old value. The result is valid once pend has dropped.
- R7: The bus runs in SPI mode 3. sck is high whenever cs_n is high. mosi changes only in the cycle in which sck falls. miso is sampled when sck rises.
- R8: Control bits [2:0] set the sck half period in system clocks, from 1 to 7, and a value of 0 acts as 1. A command with N bits on the bus keeps pend high for exactly (2N+1) times the half period.
- R9: When command bit [18] (keep-selected) is 1, cs_n stays low after the command completes. When it is 0, cs_n goes high.
- R10: A command accepted while chip select is held, with all lengths zero and bit [18] clear, produces no sck pulse and only releases chip select.
- R11: A command write while pend is high, or one with a data length above 4, sets err and is ignored: no bus activity starts. A write that falls in the same cycle as a completion is judged against the pend value before that edge.
- R12: Writing 1 to control bit [8] clears err. Writing 0 there leaves err unchanged.
- R13: Writes to the address, data or half-period fields while pend is high are ignored and do not set err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 data, 2 command, 3 control |
| wr_data | input | 32 | Register write value |
| data_q | output | 32 | Current data register contents |
| pend | output | 1 | Command in progress |
| err | output | 1 | Sticky command error |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Completion of a running command and the arrival of a new command write can land on the same clock edge. In that case the new write must be rejected, because pend is still high before that edge, and it must not restart the bus. The bench starts a command whose pending time it computes from the bit count and half period. It then presents the next command write in exactly the cycle whose edge ends the first one. It checks that err is set, that pend drops, and that no further sck edges or mosi bits appear while cs_n stays high.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam int OPC_W      = 8;
  localparam int ALEN_W     = 2;
  localparam int DUM_W      = 4;
  localparam int DLEN_W     = 3;
  localparam int DIV_W      = 3;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 32;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int MAX_BYTES  = 1 + ADDR_BYTES + (2**DUM_W - 1) + DATA_BYTES;
  localparam int CNT_W      = $clog2(8 * MAX_BYTES + 1);
  localparam int POS_W      = $clog2(DATA_W);
  localparam int CLR_BIT    = 8;

  typedef enum logic [1:0] {SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_CMD = 2'd2, SEL_CTRL = 2'd3} sel_e;
  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT} phase_e;

  // packed LSB-first: opcode [7:0], alen [9:8], dummy [13:10], dlen [16:14], write [17], keep [18]
  typedef struct packed {
    logic              keep;
    logic              wr;
    logic [DLEN_W-1:0] dlen;
    logic [DUM_W-1:0]  dum;
    logic [ALEN_W-1:0] alen;
    logic [OPC_W-1:0]  opc;
  } cmd_t;
  localparam int CMD_W = $bits(cmd_t);

  function automatic logic [CNT_W-1:0] cmd_bits(input logic [ALEN_W-1:0] al, input logic [DUM_W-1:0] dm,
                                                input logic [DLEN_W-1:0] dl, input logic with_op);
    return CNT_W'(8 * ((with_op ? 1 : 0) + int'(al) + int'(dm) + int'(dl)));
  endfunction

  function automatic phase_e byte_phase(input int idx, input logic [ALEN_W-1:0] al,
                                        input logic [DUM_W-1:0] dm, input logic with_op);
    int s;
    s = idx - (with_op ? 1 : 0);
    if (s < 0) return PH_OPC;
    if (s < int'(al)) return PH_ADR;
    if (s < int'(al) + int'(dm)) return PH_DUM;
    return PH_DAT;
  endfunction

  function automatic int phase_off(input int idx, input logic [ALEN_W-1:0] al,
                                   input logic [DUM_W-1:0] dm, input logic with_op);
    int s;
    s = idx - (with_op ? 1 : 0);
    if (s < 0) return 0;
    if (s < int'(al)) return s;
    s = s - int'(al);
    if (s < int'(dm)) return s;
    return s - int'(dm);
  endfunction

  function automatic logic [7:0] tx_byte(input phase_e ph, input int off, input logic [OPC_W-1:0] opc,
                                         input logic [ALEN_W-1:0] al, input logic wr,
                                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    case (ph)
      PH_OPC:  return opc;
      PH_ADR:  return 8'(a >> (8 * (int'(al) - 1 - off)));
      PH_DAT:  return wr ? 8'(d >> (8 * off)) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfc_tick.sv
`timescale 1ns/1ps
module sfc_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R8
  half_period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));
endmodule

// File: rtl/sfc_regs.sv
`timescale 1ns/1ps
module sfc_regs
  import sfc_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RST = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pend,
  input  logic              cap_en,
  input  logic [POS_W-1:0]  cap_pos,
  input  logic              cap_val,
  output cmd_t              cmd_w,
  output logic              cmd_go,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              err_q
);
  logic is_cmd, len_bad, cmd_reject, err_clr, free_wr;

  assign cmd_w      = cmd_t'(wr_data[CMD_W-1:0]);
  assign is_cmd     = wr_en && (wr_sel == SEL_CMD);
  assign len_bad    = int'(cmd_w.dlen) > DATA_BYTES;
  assign cmd_go     = is_cmd && !pend && !len_bad;
  assign cmd_reject = is_cmd && (pend || len_bad);
  assign err_clr    = wr_en && (wr_sel == SEL_CTRL) && wr_data[CLR_BIT];
  assign free_wr    = wr_en && !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      div_q  <= DIV_RST;
      err_q  <= 1'b0;
    end else begin
      if (free_wr && wr_sel == SEL_ADDR) addr_q <= wr_data[ADDR_W-1:0];
      if (cap_en)                              data_q[cap_pos] <= cap_val;
      else if (free_wr && wr_sel == SEL_DATA)  data_q <= wr_data;
      if (free_wr && wr_sel == SEL_CTRL) div_q <= wr_data[DIV_W-1:0];
      if (cmd_reject)   err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  // R11
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> err_q);
  // R11
  go_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> pend);
  // R13
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cap_en) |=> $stable(data_q));
endmodule

// File: rtl/sfc_shift.sv
`timescale 1ns/1ps
module sfc_shift
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic              cap_en,
  output logic [POS_W-1:0]  cap_pos,
  output logic              cap_val
);
  logic             busy_q, sck_q, cs_n_q, mosi_q, with_op_q;
  cmd_t             cmd_q;
  logic [CNT_W-1:0] bit_q, nbits;
  int               byte_i, off_i;
  phase_e           ph;
  logic [7:0]       txb;
  logic [2:0]       bpos;
  logic             at_end, fall_ev, rise_ev, done_ev;

  always_comb begin
    byte_i = int'(bit_q[CNT_W-1:3]);
    bpos   = 3'd7 - bit_q[2:0];
    nbits  = cmd_bits(cmd_q.alen, cmd_q.dum, cmd_q.dlen, with_op_q);
    ph     = byte_phase(byte_i, cmd_q.alen, cmd_q.dum, with_op_q);
    off_i  = phase_off(byte_i, cmd_q.alen, cmd_q.dum, with_op_q);
    txb    = tx_byte(ph, off_i, cmd_q.opc, cmd_q.alen, cmd_q.wr, addr, data);
  end

  assign at_end  = (bit_q == nbits);
  assign fall_ev = busy_q && tick && sck_q && !at_end;
  assign rise_ev = busy_q && tick && !sck_q;
  assign done_ev = busy_q && tick && sck_q && at_end;
  assign cap_en  = rise_ev && (ph == PH_DAT) && !cmd_q.wr;
  assign cap_pos = POS_W'(8 * off_i + int'(bpos));
  assign cap_val = miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sck_q <= 1'b1; cs_n_q <= 1'b1; mosi_q <= 1'b0;
      with_op_q <= 1'b0; cmd_q <= '0; bit_q <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      sck_q     <= 1'b1;
      cs_n_q    <= 1'b0;
      with_op_q <= cs_n_q;
      cmd_q     <= cmd_in;
      bit_q     <= '0;
    end else begin
      if (fall_ev) begin
        sck_q  <= 1'b0;
        mosi_q <= txb[bpos];
      end
      if (rise_ev) begin
        sck_q <= 1'b1;
        bit_q <= bit_q + 1'b1;
      end
      if (done_ev) begin
        busy_q <= 1'b0;
        cs_n_q <= !cmd_q.keep;
      end
    end
  end

  assign busy = busy_q;
  assign sck  = sck_q;
  assign cs_n = cs_n_q;
  assign mosi = mosi_q;

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sck_q);
  // R7
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_q) |-> $fell(sck_q));
  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (cs_n_q != $past(cmd_q.keep)));
  // R10
  release_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && nbits == '0) |-> sck_q);
endmodule

// File: rtl/sflash_cmd_seq.sv
`timescale 1ns/1ps
module sflash_cmd_seq
  import sfc_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RST = 3'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] data_q,
  output logic        pend,
  output logic        err,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  cmd_t              cmd_w;
  logic              cmd_go, tick, busy, cap_en, cap_val;
  logic [POS_W-1:0]  cap_pos;
  logic [ADDR_W-1:0] addr_w;
  logic [DIV_W-1:0]  div_w;

  sfc_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pend(busy), .cap_en(cap_en), .cap_pos(cap_pos), .cap_val(cap_val),
    .cmd_w(cmd_w), .cmd_go(cmd_go), .addr_q(addr_w), .data_q(data_q),
    .div_q(div_w), .err_q(err)
  );

  sfc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_w), .tick(tick)
  );

  sfc_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(cmd_go), .cmd_in(cmd_w), .addr(addr_w),
    .data(data_q), .tick(tick), .miso(miso), .busy(busy), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .cap_en(cap_en), .cap_pos(cap_pos), .cap_val(cap_val)
  );

  assign pend = busy;
endmodule

// File: tb/sim_sflash_cmd_seq.sv
`timescale 1ns/1ps
module sim_sflash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data, data_q;
  logic        pend, err, sck, cs_n, mosi, miso;

  always #2.5 clk = ~clk;

  sflash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_q(data_q), .pend(pend), .err(err), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_bad = 0;
  int mo_cnt, fall_cnt, idle_bad, edge_bad;
  int mo0 = 0, fall0 = 0;
  logic [31:0]  pat_q = '0;
  logic [255:0] mo_bits;
  logic sck_prev, mosi_prev;

  // bus monitor and miso model: sample away from the rising clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mo_cnt = 0; fall_cnt = 0; idle_bad = 0; edge_bad = 0; miso = 1'b0; mo_bits = '0;
    end else begin
      if (cs_n && !sck) idle_bad++;
      if (mosi !== mosi_prev && !(sck_prev && !sck)) edge_bad++;
      if (!cs_n && sck && !sck_prev) begin
        mo_bits[mo_cnt[7:0]] = mosi;
        mo_cnt++;
      end
      if (sck_prev && !sck) begin
        miso = pat_q[(fall_cnt - fall0) & 31];
        fall_cnt++;
      end
    end
    sck_prev  = sck;
    mosi_prev = mosi;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary(input int extra);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + extra, n_bad + extra);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    summary(1);
    $finish;
  end

  // {half period, command, address, data preset, miso pattern}
  localparam logic [127:0] VEC [8] = '{
    {8'd1, 24'h000006, 32'h00000000, 32'h11223344, 32'h00000000},
    {8'd2, 24'h010303, 32'h00123456, 32'hFFFFFFFF, 32'hA5C30F96},
    {8'd3, 24'h04870B, 32'h00ABCDEF, 32'h87654321, 32'h3C5A9166},
    {8'd1, 24'h06C000, 32'h00000000, 32'h00C0FFEE, 32'h00000000},
    {8'd1, 24'h000000, 32'h00000000, 32'h13579BDF, 32'h00000000},
    {8'd0, 24'h024A02, 32'h0000BEEF, 32'h0000005A, 32'h00000000},
    {8'd7, 24'h00C09F, 32'h00000000, 32'hCAFEF00D, 32'h6B2D4E71},
    {8'd4, 24'h023D35, 32'h00000077, 32'h00000000, 32'h00000000}
  };

  initial begin
    logic held;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n", 32'(cs_n), 32'd1);
    chk("R1", "sck", 32'(sck), 32'd1);
    chk("R1", "mosi", 32'(mosi), 32'd0);
    chk("R1", "pend", 32'(pend), 32'd0);
    chk("R1", "err", 32'(err), 32'd0);
    chk("R1", "data", data_q, 32'd0);

    held = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] eb [24];
      logic [31:0] cmd, adr, dat, exd;
      int hp, nb, pre, al, dm, dl, cyc, bad;
      logic wrd, kp;
      cmd = {8'h00, VEC[v][119:96]}; adr = VEC[v][95:64]; dat = VEC[v][63:32];
      hp = (VEC[v][127:120] == 0) ? 1 : int'(VEC[v][127:120]);
      al = int'(cmd[9:8]); dm = int'(cmd[13:10]); dl = int'(cmd[16:14]);
      wrd = cmd[17]; kp = cmd[18];
      wr(2'd3, {24'h0, VEC[v][127:120]});
      wr(2'd0, adr);
      wr(2'd1, dat);
      pat_q = VEC[v][31:0]; mo0 = mo_cnt; fall0 = fall_cnt;
      wr(2'd2, cmd);
      cyc = 0;
      while (pend && cyc < 5000) begin cyc++; @(negedge clk); end
      // expected byte stream built from the requirements
      nb = 0;
      if (!held) begin eb[nb] = cmd[7:0]; nb++; end
      for (int k = al - 1; k >= 0; k--) begin eb[nb] = adr[8*k +: 8]; nb++; end
      for (int k = 0; k < dm; k++) begin eb[nb] = 8'h00; nb++; end
      for (int k = 0; k < dl; k++) begin eb[nb] = wrd ? dat[8*k +: 8] : 8'h00; nb++; end
      pre = nb - dl;
      chk("R2 R3 R4 R5 R10", "bit count", 32'(mo_cnt - mo0), 32'(8 * nb));
      bad = 0;
      for (int i = 0; i < 8 * nb; i++)
        if (mo_bits[(mo0 + i) & 255] !== eb[i / 8][7 - (i % 8)]) bad++;
      chk("R2 R3 R4 R5", "mosi bit mismatches", 32'(bad), 32'd0);
      chk("R8", "pending cycles", 32'(cyc), 32'((2 * 8 * nb + 1) * hp));
      chk("R9", "cs_n after command", 32'(cs_n), 32'(!kp));
      exd = dat;
      if (!wrd)
        for (int k = 0; k < dl; k++)
          for (int b = 0; b < 8; b++)
            exd[8*k + b] = pat_q[(8 * (pre + k) + 7 - b) % 32];
      chk("R5 R6", "data register", data_q, exd);
      chk("R11", "no error", 32'(err), 32'd0);
      held = kp;
    end
    chk("R7", "sck low while deselected", 32'(idle_bad), 32'd0);
    chk("R7", "mosi change off falling edge", 32'(edge_bad), 32'd0);

    // R13 data write while pending is ignored and raises no error
    wr(2'd3, 32'h1);
    wr(2'd1, 32'h01020304);
    wr(2'd2, 32'h000006);
    wr(2'd1, 32'hDEADBEEF);
    while (pend) @(negedge clk);
    chk("R13", "data kept", data_q, 32'h01020304);
    chk("R13", "no error", 32'(err), 32'd0);

    // R11 command write in the completion cycle: 8 bits, half period 1 -> 17 cycles
    wr(2'd2, 32'h000006);
    repeat (16) @(negedge clk);
    chk("R11", "still pending before collision", 32'(pend), 32'd1);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h000006;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11", "collision err", 32'(err), 32'd1);
    chk("R11", "collision pend", 32'(pend), 32'd0);
    mo0 = mo_cnt;
    repeat (20) @(negedge clk);
    chk("R11", "no bus activity after reject", 32'(mo_cnt - mo0), 32'd0);
    chk("R11", "cs_n stays high", 32'(cs_n), 32'd1);

    // R12 error clear only by writing 1 to control bit 8
    wr(2'd3, 32'h001);
    chk("R12", "err kept on zero write", 32'(err), 32'd1);
    wr(2'd3, 32'h101);
    chk("R12", "err cleared", 32'(err), 32'd0);

    // R11 data length above 4 rejected
    wr(2'd2, 32'h014006);
    chk("R11", "dlen 5 err", 32'(err), 32'd1);
    chk("R11", "dlen 5 no pend", 32'(pend), 32'd0);
    wr(2'd3, 32'h101);

    // R11 command write during a running command is ignored
    mo0 = mo_cnt;
    wr(2'd2, 32'h000006);
    wr(2'd2, 32'h0000A5);
    chk("R11", "mid-command err", 32'(err), 32'd1);
    while (pend) @(negedge clk);
    begin
      logic [7:0] got;
      for (int i = 0; i < 8; i++) got[7 - i] = mo_bits[(mo0 + i) & 255];
      chk("R2 R11", "first opcode only bits", 32'(mo_cnt - mo0), 32'd8);
      chk("R2 R11", "first opcode only value", 32'(got), 32'h06);
    end

    summary(0);
    $finish;
  end
endmodule